// File: doc/BRIEF.md
# ADC Start-of-Conversion Sequencer

This block schedules work for one multiplexed analog-to-digital converter. It has sixteen independent request slots. Each slot is programmed with the analog input it samples, the trigger line that starts it, an optional interrupt line that can also start it, and the length of its sample window. A trigger marks the slot as pending. An arbiter then takes the pending slots one at a time, lowest slot number first. For each slot it drives the input-mux code and runs a sample phase followed by a convert phase. It stores the returned 12-bit code in that slot's own result register and emits a one-cycle end-of-conversion pulse for the slot.

Interrupt outputs are sticky flags. Each one is set by an event from one chosen slot. A single global bit selects whether that event is the start of the slot's sample window or the latching of its result. Each flag is set again only after a clear, unless its continuous bit is set. When an interrupt flag fires, it can start further slots, so conversions can be chained. The converter itself is not part of this block. It appears as a code input that is captured on the last convert cycle.

Top module: `soc_sequencer`

## Requirements
- R1: After reset, every result register reads 0, all overflow flags, interrupt outputs and end-of-conversion pulses are 0, and neither `adcSample` nor `adcConvert` is high.
- R2: Writing address s (0..15) configures slot s with these fields: channel in wrData[3:0], trigger line in wrData[4 +: log2(NUM_TRIG)], acquisition value in wrData[8 +: ACQ_W], interrupt-start select in wrData[15:14]. While slot s is being sampled or converted, `adcMuxSel` equals its channel code, where codes 0..7 are bank A inputs 0..7 and codes 8..15 are bank B inputs 0..7.
- R3: A slot's sample window (`adcSample` high) lasts its acquisition value plus one cycles. It is followed at once by exactly CONV_CYCLES (13) cycles of `adcConvert`. The two phases never overlap.
- R4: The code on `adcCode` in the last convert cycle is written to the slot's result register. In the following cycle `eocPulse` is one-hot on that slot and `rdData` for that slot already shows the new code.
- R5: A slot whose trigger never fires performs no conversion, and its result stays 0.
- R6: When several slots are pending, the lowest-numbered one is served first. Its pending flag clears as its sample window starts, so a new trigger from then on queues it again.
- R7: A trigger that arrives for a slot that is still pending sets that slot's sticky `ovfFlag` bit, and only one conversion results.
- R8: An interrupt-start select of k (1..NUM_INTS) also starts the slot whenever interrupt line k-1 fires. A select of 0 leaves only the trigger line.
- R9: Address 16+i configures interrupt i: source slot in wrData[3:0], enable in wrData[4], continuous in wrData[5]. An interrupt output is raised only by its enabled source slot.
- R10: Address 31 bit 0 is the pulse position. At 1, an interrupt is raised one cycle after its source's end-of-conversion pulse. At 0, it is raised one cycle after the source's sample window starts.
- R11: With continuous off, a new event on an interrupt whose flag is set neither changes the flag nor starts chained slots. With continuous on, every event fires. `intClr[i]` clears flag i.
- R12: A pulse on a trigger line starts only the slots that select that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 5 | Configuration address |
| wrData | input | 16 | Configuration write data |
| extTrig | input | NUM_TRIG | Trigger lines, one cycle high per trigger |
| intClr | input | NUM_INTS | Interrupt flag clears |
| rdSlot | input | 4 | Slot whose result is shown on rdData |
| rdData | output | RES_W | Result register of rdSlot |
| adcCode | input | RES_W | Code returned by the converter |
| adcMuxSel | output | 4 | Analog input selection |
| adcSample | output | 1 | Sample window active |
| adcConvert | output | 1 | Conversion active |
| eocPulse | output | 16 | Per-slot end-of-conversion pulse |
| ovfFlag | output | 16 | Per-slot sticky overflow |
| intOut | output | NUM_INTS | Interrupt flags |

## Verification
The bench builds the block with ACQ_W = 4, four trigger lines, two interrupt lines and the default 13-cycle conversion. This makes every sample-window length from 1 to 16 cycles reachable in a sweep that visits all sixteen slots, each with its own channel. The small sizes also let a short run cover re-triggering of a slot while its own conversion is in progress, mixed with overflow on queued slots. Interrupt chaining is exercised with both pulse positions and both continuous settings.

// File: rtl/soc_seq_pkg.sv
package soc_seq_pkg;
  localparam int SLOTS  = 16;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CHAN_W = 4;

  // strobes from the sequencing control into the datapath
  typedef struct packed {
    logic              startSample;
    logic              latchResult;
    logic [SLOT_W-1:0] slot;
  } seqStrobe_t;
endpackage

// File: rtl/soc_seq_ctrl.sv
module soc_seq_ctrl
  import soc_seq_pkg::*;
#(
  parameter int ACQ_W       = 6,
  parameter int CONV_CYCLES = 13
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SLOTS-1:0]            pending,
  input  logic [SLOTS-1:0][ACQ_W-1:0] acqTable,
  output seqStrobe_t                  strobe,
  output logic [SLOT_W-1:0]           curSlot,
  output logic                        sampling,
  output logic                        converting
);
  localparam int CONV_W = $clog2(CONV_CYCLES + 1);
  localparam int CNT_W  = (CONV_W > ACQ_W) ? CONV_W : ACQ_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} seqState_t;

  seqState_t         state;
  logic [CNT_W-1:0]  phaseCnt;
  logic [SLOT_W-1:0] pick;
  logic              anyPending;

  // fixed priority: lowest slot number wins
  always_comb begin
    pick       = '0;
    anyPending = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pick       = SLOT_W'(i);
        anyPending = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.startSample = (state == ST_IDLE) && anyPending;
    strobe.latchResult = (state == ST_CONV) && (phaseCnt == '0);
    strobe.slot        = strobe.startSample ? pick : curSlot;
  end

  assign sampling   = (state == ST_SAMPLE);
  assign converting = (state == ST_CONV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      curSlot  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (anyPending) begin
          state    <= ST_SAMPLE;
          curSlot  <= pick;
          phaseCnt <= CNT_W'(acqTable[pick]);
        end
        ST_SAMPLE: if (phaseCnt == '0) begin
          state    <= ST_CONV;
          phaseCnt <= CNT_W'(CONV_CYCLES - 1);
        end else begin
          phaseCnt <= phaseCnt - 1'b1;
        end
        ST_CONV: if (phaseCnt == '0) begin
          state <= ST_IDLE;
        end else begin
          phaseCnt <= phaseCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/soc_seq_dp.sv
module soc_seq_dp
  import soc_seq_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int ACQ_W    = 6,
  parameter int RES_W    = 12,
  parameter int NUM_INTS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [4:0]                  wrAddr,
  input  logic [15:0]                 wrData,
  input  logic [NUM_TRIG-1:0]         extTrig,
  input  logic [NUM_INTS-1:0]         intClr,
  input  seqStrobe_t                  strobe,
  input  logic [SLOT_W-1:0]           curSlot,
  input  logic [RES_W-1:0]            adcCode,
  input  logic [SLOT_W-1:0]           rdSlot,
  output logic [SLOTS-1:0]            pending,
  output logic [SLOTS-1:0][ACQ_W-1:0] acqTable,
  output logic [CHAN_W-1:0]           muxSel,
  output logic [RES_W-1:0]            rdData,
  output logic [SLOTS-1:0]            eocPulse,
  output logic [SLOTS-1:0]            ovfFlag,
  output logic [NUM_INTS-1:0]         intOut
);
  localparam int TRIG_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam int ISEL_W = 2;
  localparam logic [4:0] GLOBAL_ADDR = 5'd31;

  logic [SLOTS-1:0][CHAN_W-1:0]    chanCfg;
  logic [SLOTS-1:0][TRIG_W-1:0]    trigCfg;
  logic [SLOTS-1:0][ISEL_W-1:0]    iselCfg;
  logic [NUM_INTS-1:0][SLOT_W-1:0] intSrc;
  logic [NUM_INTS-1:0]             intEn, intCont, intFire;
  logic                            pulsePos;
  logic [SLOTS-1:0][RES_W-1:0]     results;
  logic [SLOTS-1:0]                startPulse, evtVec, hit, clrVec;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanCfg  <= '0;
      trigCfg  <= '0;
      acqTable <= '0;
      iselCfg  <= '0;
      intSrc   <= '0;
      intEn    <= '0;
      intCont  <= '0;
      pulsePos <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr < 5'(SLOTS)) begin
        chanCfg[wrAddr[SLOT_W-1:0]]  <= wrData[3:0];
        trigCfg[wrAddr[SLOT_W-1:0]]  <= wrData[4 +: TRIG_W];
        acqTable[wrAddr[SLOT_W-1:0]] <= wrData[8 +: ACQ_W];
        iselCfg[wrAddr[SLOT_W-1:0]]  <= wrData[15:14];
      end
      for (int i = 0; i < NUM_INTS; i++) begin
        if (wrAddr == 5'(SLOTS + i)) begin
          intSrc[i]  <= wrData[SLOT_W-1:0];
          intEn[i]   <= wrData[4];
          intCont[i] <= wrData[5];
        end
      end
      if (wrAddr == GLOBAL_ADDR) pulsePos <= wrData[0];
    end
  end

  // trigger decode per slot
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      hit[s] = extTrig[trigCfg[s]];
      for (int j = 0; j < NUM_INTS; j++) begin
        if (iselCfg[s] == ISEL_W'(j + 1) && intFire[j]) hit[s] = 1'b1;
      end
      clrVec[s] = strobe.startSample && (strobe.slot == SLOT_W'(s));
    end
  end

  assign evtVec = pulsePos ? eocPulse : startPulse;

  always_comb begin
    for (int i = 0; i < NUM_INTS; i++) begin
      intFire[i] = intEn[i] && evtVec[intSrc[i]] && (intCont[i] || !intOut[i]);
    end
  end

  // pending, overflow, results, events, interrupt flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= '0;
      ovfFlag    <= '0;
      results    <= '0;
      eocPulse   <= '0;
      startPulse <= '0;
      intOut     <= '0;
    end else begin
      pending    <= (pending & ~clrVec) | hit;
      ovfFlag    <= ovfFlag | (hit & pending & ~clrVec);
      startPulse <= clrVec;
      eocPulse   <= '0;
      if (strobe.latchResult) begin
        results[strobe.slot]  <= adcCode;
        eocPulse[strobe.slot] <= 1'b1;
      end
      for (int i = 0; i < NUM_INTS; i++) begin
        if (intFire[i])     intOut[i] <= 1'b1;
        else if (intClr[i]) intOut[i] <= 1'b0;
      end
    end
  end

  assign muxSel = chanCfg[curSlot];
  assign rdData = results[rdSlot];
endmodule

// File: rtl/soc_sequencer.sv
module soc_sequencer
  import soc_seq_pkg::*;
#(
  parameter int NUM_TRIG    = 4,
  parameter int ACQ_W       = 6,
  parameter int RES_W       = 12,
  parameter int NUM_INTS    = 2,
  parameter int CONV_CYCLES = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [4:0]          wrAddr,
  input  logic [15:0]         wrData,
  input  logic [NUM_TRIG-1:0] extTrig,
  input  logic [NUM_INTS-1:0] intClr,
  input  logic [3:0]          rdSlot,
  output logic [RES_W-1:0]    rdData,
  input  logic [RES_W-1:0]    adcCode,
  output logic [3:0]          adcMuxSel,
  output logic                adcSample,
  output logic                adcConvert,
  output logic [15:0]         eocPulse,
  output logic [15:0]         ovfFlag,
  output logic [NUM_INTS-1:0] intOut
);
  seqStrobe_t                  strobe;
  logic [SLOT_W-1:0]           curSlot;
  logic [SLOTS-1:0]            pending;
  logic [SLOTS-1:0][ACQ_W-1:0] acqTable;

  soc_seq_ctrl #(.ACQ_W(ACQ_W), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .acqTable(acqTable),
    .strobe(strobe), .curSlot(curSlot), .sampling(adcSample), .converting(adcConvert)
  );

  soc_seq_dp #(.NUM_TRIG(NUM_TRIG), .ACQ_W(ACQ_W), .RES_W(RES_W), .NUM_INTS(NUM_INTS)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTrig(extTrig), .intClr(intClr), .strobe(strobe), .curSlot(curSlot),
    .adcCode(adcCode), .rdSlot(rdSlot), .pending(pending), .acqTable(acqTable),
    .muxSel(adcMuxSel), .rdData(rdData), .eocPulse(eocPulse), .ovfFlag(ovfFlag),
    .intOut(intOut)
  );
endmodule

// File: rtl/soc_seq_checks.sv
module soc_seq_checks (
  input logic        clk,
  input logic        rstN,
  input logic        adcSample,
  input logic        adcConvert,
  input logic [3:0]  adcMuxSel,
  input logic [15:0] eocPulse
);
  assert_phase_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(adcSample && adcConvert));

  assert_conv_follows_sample_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcConvert) |-> $past(adcSample));

  assert_sample_hands_to_conv_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcSample) |-> adcConvert);

  assert_mux_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (adcConvert && $past(adcConvert)) |-> $stable(adcMuxSel));

  assert_eoc_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(eocPulse));

  assert_eoc_after_conv_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|eocPulse) |-> ($past(adcConvert) && !adcConvert));
endmodule

bind soc_sequencer soc_seq_checks u_checks (
  .clk(clk), .rstN(rstN), .adcSample(adcSample), .adcConvert(adcConvert),
  .adcMuxSel(adcMuxSel), .eocPulse(eocPulse)
);

// File: tb/test_soc_sequencer.sv
`timescale 1ns/1ps
module test_soc_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  extTrig = '0;
  logic [1:0]  intClr = '0;
  logic [3:0]  rdSlot = '0;
  logic [11:0] rdData, adcCode;
  logic [3:0]  adcMuxSel;
  logic        adcSample, adcConvert;
  logic [15:0] eocPulse, ovfFlag;
  logic [1:0]  intOut;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign adcCode = {adcMuxSel, 8'h35};

  soc_sequencer #(.NUM_TRIG(4), .ACQ_W(4), .RES_W(12), .NUM_INTS(2), .CONV_CYCLES(13)) i_soc_sequencer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTrig(extTrig), .intClr(intClr), .rdSlot(rdSlot), .rdData(rdData),
    .adcCode(adcCode), .adcMuxSel(adcMuxSel), .adcSample(adcSample),
    .adcConvert(adcConvert), .eocPulse(eocPulse), .ovfFlag(ovfFlag), .intOut(intOut)
  );

  function automatic int expCode(input int chan);
    return (chan * 256 + 'h35) % 4096;
  endfunction

  function automatic logic [15:0] slotWord(input int chan, input int line, input int acq, input int isel);
    return 16'(chan | (line << 4) | (acq << 8) | (isel << 14));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseTrig(input int line);
    @(negedge clk);
    extTrig[line] = 1'b1;
    @(negedge clk);
    extTrig = '0;
  endtask

  task automatic clearInt(input int i);
    @(negedge clk);
    intClr[i] = 1'b1;
    @(negedge clk);
    intClr = '0;
  endtask

  task automatic quietCheck(input int cycles, input string req);
    int busy = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (adcSample || adcConvert) busy++;
    end
    check(busy == 0, req, busy, 0);
  endtask

  task automatic runOne(input int slot, input int chan, input int acq);
    int sCnt = 0, cCnt = 0, muxBad = 0, guard = 0;
    rdSlot = 4'(slot);
    while (!adcSample && guard < 300) begin @(negedge clk); guard++; end
    while (adcSample && sCnt < 100) begin
      if (adcMuxSel != 4'(chan)) muxBad++;
      sCnt++; @(negedge clk);
    end
    while (adcConvert && cCnt < 100) begin
      if (adcMuxSel != 4'(chan)) muxBad++;
      cCnt++; @(negedge clk);
    end
    check(sCnt == acq + 1, "R3 sample window length", sCnt, acq + 1);
    check(cCnt == 13, "R3 conversion length", cCnt, 13);
    check(muxBad == 0, "R2 mux select held on channel", muxBad, 0);
    check(eocPulse == 16'(1 << slot), "R4 eoc pulse slot", eocPulse, 1 << slot);
    check(int'(rdData) == expCode(chan), "R4 result register", rdData, expCode(chan));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int order[4];
    int n, guard, bad;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    bad = 0;
    for (int s = 0; s < 16; s++) begin
      rdSlot = 4'(s); #0.1;
      if (rdData != 0) bad++;
    end
    check(bad == 0, "R1 results zero after reset", bad, 0);
    check(ovfFlag == 0 && eocPulse == 0 && intOut == 0, "R1 flags clear",
          {ovfFlag, eocPulse}, 0);
    check(!adcSample && !adcConvert, "R1 converter idle", {adcSample, adcConvert}, 0);

    // park every slot on line 2, which the sweep never pulses
    for (int s = 0; s < 16; s++) wr(s, slotWord(s, 2, 0, 0));

    // R12 / R5: other lines start nothing
    pulseTrig(0);
    pulseTrig(3);
    quietCheck(20, "R12 unselected lines start no slot");

    // sweep every slot with its own channel and window
    for (int s = 0; s < 16; s++) begin
      int chan = (s * 7 + 3) % 16;
      wr(s, slotWord(chan, 1, s, 0));
      pulseTrig(1);
      runOne(s, chan, s);
      if (s < 15) begin
        rdSlot = 4'(s + 1); #0.1;
        check(rdData == 0, "R5 untriggered slot keeps zero", rdData, 0);
      end
      wr(s, slotWord(chan, 2, s, 0));
    end
    check(ovfFlag == 0, "R7 no overflow in sweep", ovfFlag, 0);

    // R6 / R7 priority and overflow
    wr(12, slotWord(12, 1, 0, 0));
    wr(7,  slotWord(7, 1, 0, 0));
    wr(3,  slotWord(3, 1, 0, 0));
    pulseTrig(1);
    guard = 0;
    while (!adcConvert && guard < 100) begin @(negedge clk); guard++; end
    pulseTrig(1);
    n = 0; guard = 0;
    while (n < 4 && guard < 400) begin
      @(negedge clk); guard++;
      if (|eocPulse) begin
        for (int k = 0; k < 16; k++) if (eocPulse[k]) order[n] = k;
        n++;
      end
    end
    check(n == 4, "R7 conversion count with requeue", n, 4);
    check(order[0] == 3, "R6 first served", order[0], 3);
    check(order[1] == 3, "R6 requeued lowest slot served next", order[1], 3);
    check(order[2] == 7, "R6 third served", order[2], 7);
    check(order[3] == 12, "R6 fourth served", order[3], 12);
    check(ovfFlag == 16'h1080, "R7 overflow on still-pending slots", ovfFlag, 'h1080);
    quietCheck(20, "R7 single conversion per pending request");
    wr(12, slotWord(12, 2, 0, 0));
    wr(7,  slotWord(7, 2, 0, 0));

    // interrupt setup
    wr(3, slotWord(5, 1, 2, 0));
    wr(9, slotWord(10, 2, 1, 1));
    wr(4, slotWord(6, 3, 0, 0));
    wr(16, 16'h0013);
    wr(17, 16'h0004);
    wr(31, 16'h0001);

    // R10 end position, R9 source, R8 chaining
    pulseTrig(1);
    runOne(3, 5, 2);
    check(intOut[0] == 0, "R10 no flag at eoc cycle", intOut[0], 0);
    @(negedge clk);
    check(intOut[0] == 1, "R9 flag after source eoc", intOut[0], 1);
    runOne(9, 10, 1);

    // R11 non-continuous: flag set, no chained start
    pulseTrig(1);
    runOne(3, 5, 2);
    quietCheck(30, "R11 set flag blocks chained start");
    check(intOut[0] == 1, "R11 flag stays set", intOut[0], 1);
    clearInt(0);
    check(intOut[0] == 0, "R11 clear drops flag", intOut[0], 0);

    // R9 disabled interrupt and foreign source
    pulseTrig(3);
    runOne(4, 6, 0);
    repeat (3) @(negedge clk);
    check(intOut == 2'b00, "R9 disabled or unrelated interrupt stays low", intOut, 0);

    // R11 continuous: fires with flag already set
    wr(16, 16'h0033);
    pulseTrig(1);
    runOne(3, 5, 2);
    runOne(9, 10, 1);
    pulseTrig(1);
    runOne(3, 5, 2);
    runOne(9, 10, 1);
    check(intOut[0] == 1, "R11 continuous flag set", intOut[0], 1);

    // R10 start position
    wr(31, 16'h0000);
    wr(16, 16'h0013);
    clearInt(0);
    pulseTrig(1);
    guard = 0;
    while (!adcSample && guard < 100) begin @(negedge clk); guard++; end
    check(intOut[0] == 0, "R10 flag low in first sample cycle", intOut[0], 0);
    @(negedge clk);
    check(intOut[0] == 1 && adcSample, "R10 flag raised during sample window",
          {intOut[0], adcSample}, 3);
    repeat (100) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule